// File: doc/BRIEF.md
# Egress Timestamp Queue

This block keeps the departure times of outgoing precision-time event frames until software collects them. Each time the transmit path signals that an event frame has left, it pulses a capture strobe together with the frame's tag (domain number, 4-bit message type and 16-bit sequence ID) and the current time, given as 30 bits of nanoseconds and the low 5 bits of seconds. The block stores the tag and time as one entry in a small first-in first-out queue.

Software reads an entry through four 16-bit data words on a simple register port. It moves to the next entry by writing a pop command. A small presentation state machine owns the data words. In state `V_IDLE` no entry is shown: the valid flag is 0 and every word reads 0. In state `V_HOLD` the entry that was popped last is shown. A pop command always reloads the words. Transition `T_LOAD` goes to `V_HOLD` when the queue holds an entry. Transition `T_DRAIN` goes to `V_IDLE` when the queue is empty. With no pop, state `V_IDLE` or `V_HOLD` stays where it is (`T_KEEP`).

A pending flag stays high for as long as the queue is not empty. The interrupt pin is that flag gated by an enable bit. The flag needs no acknowledge. It falls when the last entry has been moved into the data words. Register map (3-bit address): 0 to 3 are the data words, 4 is the pop control, 5 is the interrupt enable, 6 is the status, and 7 reads 0.

Top module: `egress_ts_queue`

## Requirements
- R1: After reset all data words and the status register read 0, the interrupt enable reads 0 and `irq` is low.
- R2: Word 0 (address 0) holds the domain number in bits 7:0, the message type in bits 11:8, seconds 4:2 in bits 14:12 and the valid flag in bit 15.
- R3: Word 1 (address 1) holds the sequence ID. Word 2 (address 2) holds nanoseconds 15:0.
- R4: Word 3 (address 3) holds nanoseconds 29:16 in bits 13:0 and seconds 1:0 in bits 15:14.
- R5: Writing 1 to bit 0 of address 4 moves the oldest queued entry into the data words with the valid flag set. Entries come out in capture order.
- R6: A pop command with the queue empty leaves the valid flag at 0 and all four data words at 0.
- R7: The data words do not change between pop commands, even when new captures arrive.
- R8: Status bit 0 (address 6) is 1 exactly while the queue holds at least one entry and is never acknowledged. `irq` equals that bit ANDed with bit 0 of address 5.
- R9: The queue holds 4 entries. A capture while it is full, with no pop in the same cycle, is discarded and sets the sticky status bit 1. Writing 1 to bit 1 of address 6 clears it.
- R10: A capture and a pop command in the same cycle both take effect. On a full queue this is not an overflow. On an empty queue the pop finds nothing and the capture is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_stb | input | 1 | Capture strobe, one cycle per departed event frame |
| cap_domain | input | 8 | Domain number of the frame |
| cap_msg_type | input | 4 | Message type of the frame |
| cap_seq_id | input | 16 | Sequence ID of the frame |
| cap_nsec | input | 30 | Nanoseconds of the departure time |
| cap_sec | input | 5 | Low seconds bits of the departure time |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt: queue not empty and enabled |

## Verification
A single capture with tag and time values whose bits do not mirror each other exposes any misplaced field in the four words. A burst of four distinct captures followed by a fifth shows the queue order, the full limit and the sticky overflow flag. Pops on an empty queue, and captures that arrive while an entry is shown, separate the two presentation states and show that the words hold their value. Capture-with-pop in the same cycle on a full queue and on an empty queue checks that neither event is lost. Toggling the enable with entries pending shows that the pin depends on the enable and the status bit does not.

// File: rtl/egq_pkg.sv
package egq_pkg;
    localparam int DOM_W  = 8;
    localparam int MSG_W  = 4;
    localparam int SEQ_W  = 16;
    localparam int NS_W   = 30;
    localparam int SEC_W  = 5;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 3;

    typedef struct packed {
        logic [DOM_W-1:0] dom;
        logic [MSG_W-1:0] msg;
        logic [SEQ_W-1:0] seq;
        logic [NS_W-1:0]  ns;
        logic [SEC_W-1:0] sec;
    } ts_entry_t;

    typedef enum logic {
        V_IDLE = 1'b0,
        V_HOLD = 1'b1
    } view_state_t;

    localparam logic [ADDR_W-1:0] A_WORD0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_WORD1 = 3'd1;
    localparam logic [ADDR_W-1:0] A_WORD2 = 3'd2;
    localparam logic [ADDR_W-1:0] A_WORD3 = 3'd3;
    localparam logic [ADDR_W-1:0] A_POP   = 3'd4;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd5;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd6;
endpackage

// File: rtl/egq_fifo.sv
module egq_fifo
    import egq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  ts_entry_t din,
    input  logic      pop,
    output ts_entry_t head,
    output logic      empty,
    output logic      full,
    output logic      drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    ts_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_pop, do_push;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_pop  = pop & ~empty;
    assign do_push = push & (~full | do_pop);
    assign drop    = push & ~do_push;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // R9: occupancy never exceeds the queue depth
    a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    // R9: an accepted capture without a pop grows the queue by one
    a_r9_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> count == CNT_W'($past(count) + 1'b1));
    // R10: capture plus pop on a full queue keeps it full
    a_r10_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && full) |=> full);
endmodule

// File: rtl/egq_view.sv
module egq_view
    import egq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pop_cmd,
    input  logic      q_empty,
    input  ts_entry_t q_head,
    output ts_entry_t shown,
    output logic      shown_valid
);
    view_state_t state, state_nx;
    ts_entry_t   shown_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= V_IDLE;
            shown <= '0;
        end else begin
            state <= state_nx;
            shown <= shown_nx;
        end
    end

    always_comb begin
        state_nx = state;
        shown_nx = shown;
        unique case (state)
            V_IDLE, V_HOLD: begin
                if (pop_cmd) begin
                    if (q_empty) begin
                        state_nx = V_IDLE;      // T_DRAIN
                        shown_nx = '0;
                    end else begin
                        state_nx = V_HOLD;      // T_LOAD
                        shown_nx = q_head;
                    end
                end
            end
            default: state_nx = V_IDLE;
        endcase
    end

    assign shown_valid = (state == V_HOLD);

    // R5: a pop with data pending shows a valid entry
    a_r5_load_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_cmd && !q_empty) |=> shown_valid);
    // R6: a pop on an empty queue shows nothing
    a_r6_drain_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_cmd && q_empty) |=> (!shown_valid && shown == '0));
    // R7: no pop, no change
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_cmd |=> ($stable(shown) && $stable(shown_valid)));
endmodule

// File: rtl/egq_regs.sv
module egq_regs
    import egq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  ts_entry_t         shown,
    input  logic              shown_valid,
    input  logic              q_pending,
    input  logic              q_drop,
    output logic [WORD_W-1:0] rdata,
    output logic              pop_cmd,
    output logic              irq
);
    logic irq_en, ovf;
    logic unused_wdata;

    assign unused_wdata = ^wdata[WORD_W-1:2];
    assign pop_cmd = wr && (addr == A_POP) && wdata[0];
    assign irq     = irq_en & q_pending;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            if (wr && addr == A_IEN) irq_en <= wdata[0];
            if (q_drop)
                ovf <= 1'b1;
            else if (wr && addr == A_STAT && wdata[1])
                ovf <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            A_WORD0: rdata = {shown_valid, shown.sec[4:2], shown.msg, shown.dom};
            A_WORD1: rdata = shown.seq;
            A_WORD2: rdata = shown.ns[15:0];
            A_WORD3: rdata = {shown.sec[1:0], shown.ns[29:16]};
            A_IEN:   rdata = {{(WORD_W-1){1'b0}}, irq_en};
            A_STAT:  rdata = {{(WORD_W-2){1'b0}}, ovf, q_pending};
            default: rdata = '0;
        endcase
    end

    // R9: a discarded capture always leaves the overflow flag set
    a_r9_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q_drop |=> ovf);
    // R9: the flag only rises after a discard
    a_r9_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(q_drop));
endmodule

// File: rtl/egress_ts_queue.sv
module egress_ts_queue
    import egq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_stb,
    input  logic [DOM_W-1:0]    cap_domain,
    input  logic [MSG_W-1:0]    cap_msg_type,
    input  logic [SEQ_W-1:0]    cap_seq_id,
    input  logic [NS_W-1:0]     cap_nsec,
    input  logic [SEC_W-1:0]    cap_sec,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                irq
);
    ts_entry_t cap_entry, head, shown;
    logic      q_empty, q_full, q_drop, pop_cmd, shown_valid;

    assign cap_entry = '{dom: cap_domain, msg: cap_msg_type, seq: cap_seq_id,
                         ns: cap_nsec, sec: cap_sec};

    egq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(cap_stb), .din(cap_entry),
        .pop(pop_cmd), .head(head), .empty(q_empty), .full(q_full),
        .drop(q_drop)
    );

    egq_view u_view (
        .clk(clk), .rst_n(rst_n), .pop_cmd(pop_cmd), .q_empty(q_empty),
        .q_head(head), .shown(shown), .shown_valid(shown_valid)
    );

    egq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
        .wdata(reg_wdata), .shown(shown), .shown_valid(shown_valid),
        .q_pending(~q_empty), .q_drop(q_drop), .rdata(reg_rdata),
        .pop_cmd(pop_cmd), .irq(irq)
    );

    // R8: the pin is never high with the queue empty
    a_r8_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !q_empty);
    // R10: a full queue plus a pop never discards
    a_r10_no_drop_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && pop_cmd) |-> !q_drop);
endmodule

// File: tb/sim_egress_ts_queue.sv
module sim_egress_ts_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_stb = 1'b0;
    logic [7:0]  cap_domain = '0;
    logic [3:0]  cap_msg_type = '0;
    logic [15:0] cap_seq_id = '0;
    logic [29:0] cap_nsec = '0;
    logic [4:0]  cap_sec = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    egress_ts_queue u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #2 v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic set_cap(input int k);
        cap_domain   = 8'h5A + 8'(k);
        cap_msg_type = 4'(k + 3);
        cap_seq_id   = 16'hC000 + 16'(k * 257);
        cap_nsec     = 30'h2ACE_1234 + 30'(k * 30'h0101_0111);
        cap_sec      = 5'(k * 7 + 9);
    endtask

    task automatic cap(input int k);
        @(negedge clk);
        set_cap(k); cap_stb = 1'b1;
        @(negedge clk);
        cap_stb = 1'b0;
    endtask

    function automatic logic [15:0] exp_w0(input int k);
        logic [4:0] s = 5'(k * 7 + 9);
        return {1'b1, s[4:2], 4'(k + 3), 8'h5A + 8'(k)};
    endfunction
    function automatic logic [15:0] exp_w3(input int k);
        logic [4:0]  s = 5'(k * 7 + 9);
        logic [29:0] n = 30'h2ACE_1234 + 30'(k * 30'h0101_0111);
        return {s[1:0], n[29:16]};
    endfunction
    function automatic logic [15:0] exp_w2(input int k);
        logic [29:0] n = 30'h2ACE_1234 + 30'(k * 30'h0101_0111);
        return n[15:0];
    endfunction

    task automatic check_entry(input string req, input int k);
        logic [15:0] v;
        rd(3'd0, v); chk({req, " word0"}, v, exp_w0(k));
        rd(3'd1, v); chk({req, " word1"}, v, 16'hC000 + 16'(k * 257));
        rd(3'd2, v); chk({req, " word2"}, v, exp_w2(k));
        rd(3'd3, v); chk({req, " word3"}, v, exp_w3(k));
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v); chk("R1 reset read", v, 16'h0);
        end
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_single;
        logic [15:0] v;
        wr(3'd5, 16'h1);
        cap(1);
        rd(3'd6, v); chk("R8 pending", v, 16'h1);
        chk("R8 irq high", irq, 1);
        wr(3'd4, 16'h1);
        check_entry("R2 R3 R4 R5", 1);
        rd(3'd6, v); chk("R8 cleared by drain", v, 16'h0);
        chk("R8 irq low", irq, 0);
    endtask

    task automatic t_empty_pop;
        logic [15:0] v;
        wr(3'd4, 16'h1);
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v); chk("R6 empty pop word", v, 16'h0);
        end
    endtask

    task automatic t_hold;
        logic [15:0] v;
        cap(2);
        wr(3'd4, 16'h1);
        cap(3);
        rd(3'd0, v); chk("R7 read twice", v, exp_w0(2));
        check_entry("R7 hold after capture", 2);
        wr(3'd4, 16'h1);
        check_entry("R5 next", 3);
    endtask

    task automatic t_overflow;
        logic [15:0] v;
        for (int k = 4; k < 8; k++) cap(k);
        cap(8);
        rd(3'd6, v); chk("R9 overflow sticky", v, 16'h3);
        wr(3'd5, 16'h0);
        chk("R8 irq gated off", irq, 0);
        rd(3'd6, v); chk("R8 status ignores enable", v[0], 1);
        wr(3'd5, 16'h1);
        chk("R8 irq back", irq, 1);
        for (int k = 4; k < 8; k++) begin
            wr(3'd4, 16'h1);
            rd(3'd1, v); chk("R5 order", v, 16'hC000 + 16'(k * 257));
        end
        wr(3'd4, 16'h1);
        rd(3'd0, v); chk("R9 fifth dropped", v, 16'h0);
        rd(3'd6, v); chk("R9 still sticky", v, 16'h2);
        wr(3'd6, 16'h2);
        rd(3'd6, v); chk("R9 clear", v, 16'h0);
    endtask

    task automatic t_same_cycle;
        logic [15:0] v;
        for (int k = 10; k < 14; k++) cap(k);
        @(negedge clk);
        set_cap(14); cap_stb = 1'b1;
        reg_addr = 3'd4; reg_wdata = 16'h1; reg_wr = 1'b1;
        @(negedge clk);
        cap_stb = 1'b0; reg_wr = 1'b0;
        check_entry("R10 full swap shows oldest", 10);
        rd(3'd6, v); chk("R10 no overflow", v, 16'h1);
        for (int k = 11; k < 15; k++) begin
            wr(3'd4, 16'h1);
            rd(3'd1, v); chk("R10 kept capture", v, 16'hC000 + 16'(k * 257));
        end
        @(negedge clk);
        set_cap(15); cap_stb = 1'b1;
        reg_addr = 3'd4; reg_wdata = 16'h1; reg_wr = 1'b1;
        @(negedge clk);
        cap_stb = 1'b0; reg_wr = 1'b0;
        rd(3'd0, v); chk("R10 R6 empty pop with capture", v, 16'h0);
        rd(3'd6, v); chk("R10 capture queued", v, 16'h1);
        wr(3'd4, 16'h1);
        check_entry("R10 queued entry", 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_empty_pop();
        t_hold();
        t_overflow();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule